// File: doc/BRIEF.md
# Bus-Mastering Block Transfer Engine

This block moves a block of bytes between system memory and a peripheral device for an 8-bit processor with a 16-bit address space. Software sets up the transfer with byte-wide register writes: a 16-bit memory pointer, a 16-bit item count and a 16-bit device-side location, each written as a low and a high byte. It then writes a control byte that gives the direction and the bus mode and starts the engine. From then on the engine runs alone, and register setup writes are ignored until the block is done.

For each item the engine first waits for the device to be ready. It then asks for the system bus, waits for the grant, and drives one memory cycle. The data passes through an internal byte register. In device-to-memory direction the byte is taken from the device before the memory write. In memory-to-device direction it is read from memory and then handed to the device. After each memory cycle both pointers step up by one and the count steps down by one.

In cycle-stealing mode the bus request is dropped after every memory cycle. In burst mode the request is held from the first grant to the end of the block. When the count runs out, an interrupt line is raised. It stays raised until software clears it.

Top module: `dma_xfer_engine`

## Requirements
- R1: Register writes use `reg_sel`: 0/1 memory pointer low/high byte, 2/3 count low/high byte, 4/5 device location low/high byte. 6 is control: bit0 = 1 starts, bit1 = 1 selects memory-to-device (0 = device-to-memory), bit2 = 1 selects burst (0 = cycle-stealing). 7 is status: writing bit0 = 1 clears the interrupt.
- R2: A memory cycle (`mem_rd` or `mem_wr` high, with `mem_addr_oe` high) happens only while `bus_req` and `bus_grant` are both high and lasts one clock. A rising `bus_req` is preceded by `dev_ready` high. `mem_addr` reads zero whenever `mem_addr_oe` is low.
- R3: The first memory cycle of a block uses the loaded pointer. `mem_addr` and `dev_addr` each advance by one after every memory cycle, wrapping from 0xFFFF to 0x0000. A block started without rewriting the pointers continues where the last one ended.
- R4: In device-to-memory direction, the byte on `dev_rdata` in the clock where `dev_strobe` and `dev_ready` are high is the byte written with `mem_wr` in the item's memory cycle.
- R5: In memory-to-device direction, the byte read in an item's memory cycle is later shown on `dev_wdata` with `dev_strobe`. `dev_strobe` is only high while `dev_ready` is high.
- R6: In cycle-stealing mode `bus_req` is low in the clock after every memory cycle.
- R7: In burst mode `bus_req`, once raised, stays high until the last memory cycle of the block is done.
- R8: A block of N items makes exactly N memory cycles. `irq` rises in the clock after the last item completes, is low during the transfer, and stays high until a status clear write.
- R9: A start with a count of zero raises `irq` in the next clock, with no bus request and no memory cycle.
- R10: Writes to `reg_sel` 0 to 6 while a block is in progress change nothing.
- R11: After reset `irq`, `bus_req`, `mem_addr_oe`, `mem_rd`, `mem_wr` and `dev_strobe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 8 | Register write data |
| irq | output | 1 | Terminal-count interrupt |
| bus_req | output | 1 | System bus request |
| bus_grant | input | 1 | System bus grant |
| mem_addr | output | 16 | Memory address, zero when not driven |
| mem_addr_oe | output | 1 | Address drive enable during a memory cycle |
| mem_rd | output | 1 | Memory read cycle |
| mem_wr | output | 1 | Memory write cycle |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data |
| dev_ready | input | 1 | Device ready handshake |
| dev_rdata | input | 8 | Byte from the device |
| dev_wdata | output | 8 | Byte to the device |
| dev_strobe | output | 1 | Device byte taken or delivered |
| dev_addr | output | 16 | Device-side location |

## Verification
The bench targets the point where a block ends. A design that tested the count at the wrong moment would make one memory cycle too many or too few, or raise the interrupt a clock early or late. It runs a pointer across 0xFFFF: a design without a clean wrap would address the wrong byte. It writes setup registers and a second start in the middle of a block: a design that let those through would jump its address or cut the count short. It also covers a zero-count start, slow grants and a ready line that toggles. A design that dropped the request too late in cycle-stealing mode, released it in burst mode, or moved data without the handshake would show up against the bench's queue-based model of the bytes and addresses.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int DW     = 8;
  localparam int AW     = 2 * DW;
  localparam int CW     = 2 * DW;
  localparam int RSEL_W = 3;

  localparam logic [RSEL_W-1:0] RA_MA_LO = 3'd0;
  localparam logic [RSEL_W-1:0] RA_MA_HI = 3'd1;
  localparam logic [RSEL_W-1:0] RA_CN_LO = 3'd2;
  localparam logic [RSEL_W-1:0] RA_CN_HI = 3'd3;
  localparam logic [RSEL_W-1:0] RA_DA_LO = 3'd4;
  localparam logic [RSEL_W-1:0] RA_DA_HI = 3'd5;
  localparam logic [RSEL_W-1:0] RA_CTRL  = 3'd6;
  localparam logic [RSEL_W-1:0] RA_STAT  = 3'd7;

  localparam int CB_GO    = 0;
  localparam int CB_TODEV = 1;
  localparam int CB_BURST = 2;
  localparam int SB_CLR   = 0;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_ACQ, ST_MEM, ST_PUT
  } dma_state_e;

  typedef struct packed {
    logic burst;
    logic to_dev;
  } dma_mode_t;
endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [RSEL_W-1:0] wr_sel,
  input  logic [DW-1:0]     wr_data,
  input  logic              step,
  output logic [AW-1:0]     maddr,
  output logic [AW-1:0]     daddr,
  output logic              cnt_zero,
  output logic              cnt_one
);
  logic [AW-1:0] ma_q, ma_d, da_q, da_d;
  logic [CW-1:0] cn_q, cn_d;
  logic          ld_en;

  assign ld_en = step | wr_en;

  always_comb begin
    ma_d = ma_q;
    da_d = da_q;
    cn_d = cn_q;
    if (step) begin
      ma_d = ma_q + AW'(1);
      da_d = da_q + AW'(1);
      cn_d = cn_q - CW'(1);
    end else if (wr_en) begin
      unique case (wr_sel)
        RA_MA_LO: ma_d[DW-1:0]    = wr_data;
        RA_MA_HI: ma_d[AW-1:DW]   = wr_data;
        RA_CN_LO: cn_d[DW-1:0]    = wr_data;
        RA_CN_HI: cn_d[CW-1:DW]   = wr_data;
        RA_DA_LO: da_d[DW-1:0]    = wr_data;
        RA_DA_HI: da_d[AW-1:DW]   = wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ma_q <= '0;
      da_q <= '0;
      cn_q <= '0;
    end else if (ld_en) begin
      ma_q <= ma_d;
      da_q <= da_d;
      cn_q <= cn_d;
    end
  end

  assign maddr    = ma_q;
  assign daddr    = da_q;
  assign cnt_zero = (cn_q == '0);
  assign cnt_one  = (cn_q == CW'(1));
endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic go_to_dev,
  input  logic go_burst,
  input  logic irq_clr,
  input  logic cnt_zero,
  input  logic cnt_one,
  input  logic dev_ready,
  input  logic bus_grant,
  output logic busy,
  output logic burst,
  output logic bus_req,
  output logic mem_on,
  output logic mem_rd,
  output logic mem_wr,
  output logic step,
  output logic cap_mem,
  output logic cap_dev,
  output logic dev_strobe,
  output logic irq
);
  dma_state_e st_q, st_d;
  dma_mode_t  mode_q, mode_d;
  logic       mode_en;
  logic       hold_q, hold_d;
  logic       irq_q, irq_d;

  always_comb begin
    st_d       = st_q;
    hold_d     = hold_q;
    irq_d      = irq_q;
    mode_d     = mode_q;
    mode_en    = 1'b0;
    step       = 1'b0;
    cap_mem    = 1'b0;
    cap_dev    = 1'b0;
    dev_strobe = 1'b0;
    mem_on     = 1'b0;
    if (irq_clr) irq_d = 1'b0;
    unique case (st_q)
      ST_IDLE: if (go) begin
        mode_en       = 1'b1;
        mode_d.to_dev = go_to_dev;
        mode_d.burst  = go_burst;
        if (cnt_zero) irq_d = 1'b1;
        else          st_d  = ST_DEV;
      end
      ST_DEV: if (dev_ready) begin
        if (!mode_q.to_dev) begin
          cap_dev    = 1'b1;
          dev_strobe = 1'b1;
        end
        st_d = ST_ACQ;
      end
      ST_ACQ: if (bus_grant) begin
        st_d = ST_MEM;
        if (mode_q.burst) hold_d = 1'b1;
      end
      ST_MEM: begin
        mem_on = 1'b1;
        step   = 1'b1;
        if (mode_q.to_dev) begin
          cap_mem = 1'b1;
          st_d    = ST_PUT;
        end else if (cnt_one) begin
          st_d   = ST_IDLE;
          hold_d = 1'b0;
          irq_d  = 1'b1;
        end else begin
          st_d = ST_DEV;
        end
      end
      ST_PUT: if (dev_ready) begin
        dev_strobe = 1'b1;
        if (cnt_zero) begin
          st_d   = ST_IDLE;
          hold_d = 1'b0;
          irq_d  = 1'b1;
        end else begin
          st_d = ST_DEV;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      hold_q <= 1'b0;
      irq_q  <= 1'b0;
      mode_q <= '0;
    end else begin
      st_q   <= st_d;
      hold_q <= hold_d;
      irq_q  <= irq_d;
      if (mode_en) mode_q <= mode_d;
    end
  end

  assign busy    = (st_q != ST_IDLE);
  assign burst   = mode_q.burst;
  assign bus_req = (st_q == ST_ACQ) || (st_q == ST_MEM) || hold_q;
  assign mem_rd  = mem_on & mode_q.to_dev;
  assign mem_wr  = mem_on & ~mode_q.to_dev;
  assign irq     = irq_q;
endmodule

// File: rtl/dma_data.sv
module dma_data
  import dma_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_mem,
  input  logic          cap_dev,
  input  logic [DW-1:0] mem_rdata,
  input  logic [DW-1:0] dev_rdata,
  output logic [DW-1:0] data_out
);
  logic [DW-1:0] data_q, data_d;
  logic          data_en;

  assign data_en = cap_mem | cap_dev;
  assign data_d  = cap_mem ? mem_rdata : dev_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_en) data_q <= data_d;
  end

  assign data_out = data_q;
endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
  import dma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [RSEL_W-1:0] reg_sel,
  input  logic [DW-1:0]     reg_wdata,
  output logic              irq,
  output logic              bus_req,
  input  logic              bus_grant,
  output logic [AW-1:0]     mem_addr,
  output logic              mem_addr_oe,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DW-1:0]     mem_wdata,
  input  logic [DW-1:0]     mem_rdata,
  input  logic              dev_ready,
  input  logic [DW-1:0]     dev_rdata,
  output logic [DW-1:0]     dev_wdata,
  output logic              dev_strobe,
  output logic [AW-1:0]     dev_addr
);
  logic [1:0]    rst_pipe;
  logic          rst_sync_n;
  logic          busy, burst, cfg_we, go, irq_clr;
  logic          step, cap_mem, cap_dev, mem_on;
  logic          cnt_zero, cnt_one;
  logic [AW-1:0] maddr;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  assign cfg_we  = reg_we & ~busy;
  assign go      = cfg_we && (reg_sel == RA_CTRL) && reg_wdata[CB_GO];
  assign irq_clr = reg_we && (reg_sel == RA_STAT) && reg_wdata[SB_CLR];

  dma_regs u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(cfg_we), .wr_sel(reg_sel),
    .wr_data(reg_wdata), .step(step), .maddr(maddr), .daddr(dev_addr),
    .cnt_zero(cnt_zero), .cnt_one(cnt_one)
  );

  dma_seq u_seq (
    .clk(clk), .rst_n(rst_sync_n), .go(go), .go_to_dev(reg_wdata[CB_TODEV]),
    .go_burst(reg_wdata[CB_BURST]), .irq_clr(irq_clr), .cnt_zero(cnt_zero),
    .cnt_one(cnt_one), .dev_ready(dev_ready), .bus_grant(bus_grant),
    .busy(busy), .burst(burst), .bus_req(bus_req), .mem_on(mem_on),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .step(step), .cap_mem(cap_mem),
    .cap_dev(cap_dev), .dev_strobe(dev_strobe), .irq(irq)
  );

  dma_data u_data (
    .clk(clk), .rst_n(rst_sync_n), .cap_mem(cap_mem), .cap_dev(cap_dev),
    .mem_rdata(mem_rdata), .dev_rdata(dev_rdata), .data_out(data_q)
  );

  assign mem_addr_oe = mem_on;
  assign mem_addr    = mem_on ? maddr : '0;
  assign mem_wdata   = data_q;
  assign dev_wdata   = data_q;
endmodule

// File: rtl/dma_xfer_chk.sv
module dma_xfer_chk (
  input logic clk,
  input logic rst_n,
  input logic bus_req,
  input logic bus_grant,
  input logic mem_addr_oe,
  input logic mem_rd,
  input logic mem_wr,
  input logic dev_strobe,
  input logic dev_ready,
  input logic irq,
  input logic irq_clr,
  input logic busy,
  input logic burst
);
  p_cycle_owned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> (bus_req && bus_grant));

  p_single_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_addr_oe |=> !mem_addr_oe);

  p_strobe_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dev_strobe |-> dev_ready);

  p_steal_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_addr_oe && !burst) |=> !bus_req);

  p_burst_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && burst && bus_req) |=> (bus_req || !busy));

  p_irq_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_req);
endmodule

bind dma_xfer_engine dma_xfer_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .bus_req(bus_req), .bus_grant(bus_grant),
  .mem_addr_oe(mem_addr_oe), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .dev_strobe(dev_strobe), .dev_ready(dev_ready), .irq(irq),
  .irq_clr(irq_clr), .busy(busy), .burst(burst)
);

// File: tb/tb_dma_xfer_engine.sv
module tb_dma_xfer_engine;
  import dma_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_sel = 3'd0;
  logic [7:0]  reg_wdata = 8'd0;
  logic        irq;
  logic        bus_req;
  logic        bus_grant = 1'b0;
  logic [15:0] mem_addr;
  logic        mem_addr_oe, mem_rd, mem_wr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        dev_ready = 1'b0;
  logic [7:0]  dev_rdata = 8'd0;
  logic [7:0]  dev_wdata;
  logic        dev_strobe;
  logic [15:0] dev_addr;

  always #4 clk = ~clk;

  dma_xfer_engine dut (.*);

  function automatic logic [7:0] mem_fn(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction
  assign mem_rdata = mem_fn(mem_addr);

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string what, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, expv);
    end
  endtask

  // reference model state
  logic [15:0] lfsr = 16'hACE1;
  bit          rdy_rand = 0, gnt_slow = 0, mon_en = 0;
  logic [15:0] exp_ma = 0, exp_da = 0;
  int          exp_left = 0, mem_cycles = 0;
  bit          m_todev = 0, m_burst = 0, active = 0, irq_due = 0, done_flag = 0;
  bit          took = 0, prev_mem = 0, prev_req = 0, ready_seen = 0;
  logic [7:0]  dev_pat = 8'h31;
  logic [7:0]  q_data[$];

  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (took) begin dev_pat = dev_pat + 8'h13; took = 0; end
    dev_rdata = dev_pat;
    dev_ready = rdy_rand ? (lfsr[0] | lfsr[5]) : 1'b1;
    bus_grant = bus_req && (bus_grant || !gnt_slow || lfsr[3]);
    #1;
    if (mon_en) begin
      logic       mc;
      logic [7:0] e;
      mc = mem_rd || mem_wr;
      if (irq_due) chk(irq, "R8 irq one clock after last item", irq, 1);
      irq_due = 0;
      if (active) chk(!irq, "R8 irq low during block", irq, 0);
      chk(mem_addr_oe || mem_addr == 16'h0, "R2 address zero when not driven", mem_addr, 0);
      if (mc) chk(bus_grant && mem_addr_oe, "R2 cycle needs grant and drive", {bus_grant, mem_addr_oe}, 3);
      if (bus_req && !prev_req) chk(ready_seen, "R2 ready before request", 0, 1);
      if (mc) ready_seen = 0;
      else if (dev_ready) ready_seen = 1;
      if (dev_strobe) chk(dev_ready, "R5 strobe only with ready", dev_ready, 1);
      if (prev_mem && !m_burst) chk(!bus_req, "R6 request dropped after item", bus_req, 0);
      if (active && m_burst && prev_req && exp_left > 0) chk(bus_req, "R7 request held in burst", bus_req, 1);
      if (mc) begin
        chk(active && exp_left > 0, "R8 no memory cycle beyond count", mem_cycles, exp_left);
        chk(mem_addr == exp_ma, "R3 memory address", mem_addr, exp_ma);
        chk(dev_addr == exp_da, "R3 device address", dev_addr, exp_da);
        chk(mem_rd == m_todev && mem_wr == !m_todev, "R1 cycle direction", {mem_rd, mem_wr}, {m_todev, !m_todev});
        if (mem_wr) begin
          if (q_data.size() == 0) chk(0, "R4 write without device byte", mem_wdata, 0);
          else begin
            e = q_data.pop_front();
            chk(mem_wdata == e, "R4 byte written to memory", mem_wdata, e);
          end
        end else begin
          q_data.push_back(mem_fn(exp_ma));
        end
        exp_ma = exp_ma + 16'd1;
        exp_da = exp_da + 16'd1;
        exp_left--;
        mem_cycles++;
        if (!m_todev && exp_left == 0) begin active = 0; irq_due = 1; done_flag = 1; end
      end
      if (dev_strobe && dev_ready) begin
        if (!m_todev) begin
          q_data.push_back(dev_rdata);
          took = 1;
        end else if (q_data.size() == 0) begin
          chk(0, "R5 strobe without memory byte", dev_wdata, 0);
        end else begin
          e = q_data.pop_front();
          chk(dev_wdata == e, "R5 byte delivered to device", dev_wdata, e);
          if (exp_left == 0 && q_data.size() == 0) begin active = 0; irq_due = 1; done_flag = 1; end
        end
      end
      prev_mem = mc;
      prev_req = bus_req;
    end
  end

  task automatic wr(input logic [2:0] sel, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic go_cmd(input bit todev, input bit burst, input int n);
    m_todev = todev; m_burst = burst;
    exp_left = n; mem_cycles = 0; done_flag = 0;
    q_data.delete();
    active = (n != 0);
    wr(3'd6, {5'b0, burst, todev, 1'b1});
  endtask

  task automatic start_xfer(input logic [15:0] ma, input logic [15:0] da, input int n,
                            input bit todev, input bit burst);
    wr(3'd0, ma[7:0]);  wr(3'd1, ma[15:8]);
    wr(3'd2, n[7:0]);   wr(3'd3, n[15:8]);
    wr(3'd4, da[7:0]);  wr(3'd5, da[15:8]);
    exp_ma = ma; exp_da = da;
    go_cmd(todev, burst, n);
  endtask

  task automatic finish_xfer(input int n, input string tag);
    int waited = 0;
    while (!done_flag && waited < 3000) begin @(negedge clk); waited++; end
    chk(done_flag, {tag, " block finished"}, done_flag, 1);
    @(negedge clk); #2;
    chk(irq, "R8 irq raised at end", irq, 1);
    chk(mem_cycles == n, "R8 memory cycles equal count", mem_cycles, n);
    repeat (4) @(negedge clk);
    #2 chk(irq, "R8 irq held until cleared", irq, 1);
    wr(3'd7, 8'h01);
    #2 chk(!irq, "R1 status write clears irq", irq, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #2;
    chk(!irq && !bus_req, "R11 irq and request low after reset", {irq, bus_req}, 0);
    chk(!mem_addr_oe && !mem_rd && !mem_wr, "R11 no memory cycle after reset", {mem_addr_oe, mem_rd, mem_wr}, 0);
    chk(!dev_strobe, "R11 no device strobe after reset", dev_strobe, 0);
    mon_en = 1;

    // R4 R6: device to memory, cycle stealing, fast partners
    start_xfer(16'h1234, 16'h0040, 5, 1'b0, 1'b0);
    finish_xfer(5, "R4");

    // R5 R6: memory to device, cycle stealing, slow partners
    rdy_rand = 1; gnt_slow = 1;
    start_xfer(16'h2F80, 16'h0100, 6, 1'b1, 1'b0);
    finish_xfer(6, "R5");

    // R7: device to memory, burst
    start_xfer(16'h0A00, 16'h0300, 7, 1'b0, 1'b1);
    finish_xfer(7, "R7");

    // R3 R7: memory to device, burst, pointer wraps
    start_xfer(16'hFFFE, 16'hFFFF, 4, 1'b1, 1'b1);
    finish_xfer(4, "R3");

    // R9: zero count
    wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    go_cmd(1'b0, 1'b0, 0);
    #2 chk(irq, "R9 zero count raises irq next clock", irq, 1);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      #2 chk(!bus_req, "R9 no request on zero count", bus_req, 0);
    end
    wr(3'd7, 8'h01);
    #2 chk(!irq, "R9 irq cleared", irq, 0);

    // R10: setup writes during a block are ignored
    start_xfer(16'h0100, 16'h0200, 6, 1'b0, 1'b0);
    repeat (2) @(negedge clk);
    wr(3'd0, 8'h55); wr(3'd1, 8'h66); wr(3'd2, 8'hFF);
    wr(3'd4, 8'h77); wr(3'd6, 8'h07);
    finish_xfer(6, "R10");
    chk(exp_ma == 16'h0106, "R10 pointer unchanged by busy writes", exp_ma, 16'h0106);

    // R3 R10: restart with only the count rewritten continues the pointers
    rdy_rand = 0; gnt_slow = 0;
    wr(3'd2, 8'h03); wr(3'd3, 8'h00);
    go_cmd(1'b1, 1'b0, 3);
    finish_xfer(3, "R3");
    chk(dev_addr == 16'h0209, "R3 device pointer continued", dev_addr, 16'h0209);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule